// File: doc/BRIEF.md
# Dirty Band Update Tracker

This block drives the redraw decision for one frame refresh. The frame is walked in horizontal bands of four lines, one band per cycle. For each band the block puts the band number on a lookup port and reads back, in the same cycle, the dirty flags that an external store holds for that band. Adjacent dirty bands are merged into one update region, given as a first line and a line count and offered to a consumer on a valid/ready handshake. While a region waits for acceptance the walk pauses.

Each band holds four lines of 1024 bytes, so one band is one 4 KiB page of the indexed-colour plane. In single-plane mode only that plane's flag counts. In mixed-depth mode a band is dirty if any of the indexed plane, the direct-colour plane or the per-pixel control plane reports a change. A full-invalidate pulse forces every band of the next walk to count as dirty. When the walk ends, the block issues one clear request. The request covers the band range from the first dirty band seen to the last one, inclusive. A one-cycle completion pulse follows.

Top module: `dbt_dirty_band_tracker`

## Requirements
- R1: After reset, rgn_valid, clr_valid, done and scan_active are all low.
- R2: When a dirty band is reached and no run is open, a run opens and its region reports the first line of that band (band number times 4) as rgn_start.
- R3: When a clean band follows an open run, a region is emitted. Its rgn_lines is the clean band's first line minus the run start, and the run closes.
- R4: A run still open when the walk passes the frame height is emitted with rgn_lines equal to the height minus the run start. This also holds when the height is not a multiple of four.
- R5: After the walk, if any band was dirty, clr_valid pulses once with clr_first the lowest and clr_last the highest dirty band. If no band was dirty, no clear is requested.
- R6: Bit 0 of plane_dirty is the indexed plane, and bits 1 and 2 are the direct-colour and control planes. With mixed_mode high a band is dirty if any bit is set. With mixed_mode low, bits 1 and 2 are ignored.
- R7: An invalidate_all pulse while idle makes every band of the next walk dirty, giving one region of the whole height and a clear of bands 0 through the last band. The walk after that is unaffected.
- R8: While rgn_valid is high and rgn_ready is low, the region fields and band_idx hold and no band is scanned.
- R9: done pulses for one cycle, on the cycle after the clear request or after the walk when there is none. frame_start has no effect while a walk is in progress.
- R10: During a walk the k-th cycle with scan_active high presents band k on band_idx, beginning at band 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a walk when idle |
| frame_lines | input | LINE_W | Frame height in lines, sampled at start |
| mixed_mode | input | 1 | Counts all planes when high |
| invalidate_all | input | 1 | Forces the next walk fully dirty |
| band_idx | output | LINE_W-2 | Band presented for dirty lookup |
| scan_active | output | 1 | band_idx is being evaluated this cycle |
| plane_dirty | input | NPLANES | Dirty flags of band_idx, one per plane |
| rgn_valid | output | 1 | Region offered |
| rgn_ready | input | 1 | Consumer accepts the region |
| rgn_start | output | LINE_W | First line of the region |
| rgn_lines | output | LINE_W | Number of lines in the region |
| clr_valid | output | 1 | Clear request pulse |
| clr_first | output | LINE_W-2 | Lowest band to clear |
| clr_last | output | LINE_W-2 | Highest band to clear |
| done | output | 1 | Walk finished pulse |

## Verification
The bench builds the block with LINE_W set to 7 and three planes, so a frame holds at most 32 bands. Every band can be given its own flag pattern, and whole frames finish in a few dozen cycles. At this size the bench can test the first band, the last band, and a partial last band at a height of 30. It also runs a frame with every band dirty, and all of these under random back-pressure on the region handshake.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EMIT,
    ST_FIN,
    ST_DONE
  } dbt_state_e;
endpackage

// File: rtl/dbt_band_sense.sv
module dbt_band_sense #(
  parameter int NPLANES = 3
) (
  input  logic [NPLANES-1:0] plane_dirty,
  input  logic               mixed_mode,
  input  logic               force_all,
  output logic               band_dirty
);
  generate
    if (NPLANES == 1) begin : g_single
      logic unused_mode;
      assign unused_mode = mixed_mode;
      assign band_dirty  = force_all | plane_dirty[0];
    end else begin : g_multi
      // plane 0 always counts; the others only in mixed-depth mode
      assign band_dirty = force_all | plane_dirty[0]
                        | (mixed_mode & (|plane_dirty[NPLANES-1:1]));
    end
  endgenerate
endmodule

// File: rtl/dbt_span_track.sv
module dbt_span_track #(
  parameter int BAND_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              hit,
  input  logic [BAND_W-1:0] band,
  output logic              any_q,
  output logic [BAND_W-1:0] lo_q,
  output logic [BAND_W-1:0] hi_q
);
  logic              any_d;
  logic [BAND_W-1:0] lo_d, hi_d;
  logic              lo_en, hi_en;

  always_comb begin
    any_d = any_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    lo_en = 1'b0;
    hi_en = 1'b0;
    if (restart) begin
      any_d = 1'b0;
    end else if (hit) begin
      any_d = 1'b1;
      hi_d  = band;
      hi_en = 1'b1;
      // the walk is monotonic, so the first hit is the lowest band
      if (!any_q) begin
        lo_d  = band;
        lo_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      any_q <= any_d;
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/dbt_dirty_band_tracker.sv
module dbt_dirty_band_tracker #(
  parameter int LINE_W  = 11,
  parameter int NPLANES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [LINE_W-1:0]   frame_lines,
  input  logic                mixed_mode,
  input  logic                invalidate_all,
  output logic [LINE_W-3:0]   band_idx,
  output logic                scan_active,
  input  logic [NPLANES-1:0]  plane_dirty,
  output logic                rgn_valid,
  input  logic                rgn_ready,
  output logic [LINE_W-1:0]   rgn_start,
  output logic [LINE_W-1:0]   rgn_lines,
  output logic                clr_valid,
  output logic [LINE_W-3:0]   clr_first,
  output logic [LINE_W-3:0]   clr_last,
  output logic                done
);
  import dbt_pkg::*;

  localparam int BAND_W = LINE_W - 2;
  localparam int YW     = LINE_W + 1;
  localparam logic [YW-1:0] BAND_LINES = YW'(4);

  dbt_state_e        state_q, state_d;
  logic [YW-1:0]     line_q, line_d;
  logic [LINE_W-1:0] height_q, height_d;
  logic              run_open_q, run_open_d;
  logic [LINE_W-1:0] run_start_q, run_start_d;
  logic [LINE_W-1:0] rstart_q, rstart_d;
  logic [LINE_W-1:0] rlines_q, rlines_d;
  logic              inv_pend_q, inv_pend_d;
  logic              inv_act_q, inv_act_d;

  logic in_frame, scan_step, band_dirty, hit, restart;
  logic span_any;
  logic [BAND_W-1:0] span_lo, span_hi;

  assign in_frame  = line_q < {1'b0, height_q};
  assign scan_step = (state_q == ST_SCAN) && in_frame;
  assign hit       = scan_step && band_dirty;
  assign restart   = (state_q == ST_IDLE) && frame_start;

  dbt_band_sense #(.NPLANES(NPLANES)) u_sense (
    .plane_dirty (plane_dirty),
    .mixed_mode  (mixed_mode),
    .force_all   (inv_act_q),
    .band_dirty  (band_dirty)
  );

  dbt_span_track #(.BAND_W(BAND_W)) u_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .hit     (hit),
    .band    (line_q[LINE_W-1:2]),
    .any_q   (span_any),
    .lo_q    (span_lo),
    .hi_q    (span_hi)
  );

  always_comb begin
    state_d     = state_q;
    line_d      = line_q;
    height_d    = height_q;
    run_open_d  = run_open_q;
    run_start_d = run_start_q;
    rstart_d    = rstart_q;
    rlines_d    = rlines_q;
    inv_pend_d  = inv_pend_q | invalidate_all;
    inv_act_d   = inv_act_q;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d    = ST_SCAN;
          line_d     = '0;
          height_d   = frame_lines;
          run_open_d = 1'b0;
          inv_act_d  = inv_pend_q | invalidate_all;
          inv_pend_d = 1'b0;
        end
      end
      ST_SCAN: begin
        if (in_frame) begin
          line_d = line_q + BAND_LINES;
          if (band_dirty) begin
            if (!run_open_q) begin
              run_open_d  = 1'b1;
              run_start_d = line_q[LINE_W-1:0];
            end
          end else if (run_open_q) begin
            rstart_d   = run_start_q;
            rlines_d   = line_q[LINE_W-1:0] - run_start_q;
            run_open_d = 1'b0;
            state_d    = ST_EMIT;
          end
        end else if (run_open_q) begin
          rstart_d   = run_start_q;
          rlines_d   = height_q - run_start_q;
          run_open_d = 1'b0;
          state_d    = ST_EMIT;
        end else begin
          state_d = ST_FIN;
        end
      end
      ST_EMIT: begin
        if (rgn_ready) state_d = ST_SCAN;
      end
      ST_FIN: begin
        state_d   = ST_DONE;
        inv_act_d = 1'b0;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      line_q      <= '0;
      height_q    <= '0;
      run_open_q  <= 1'b0;
      run_start_q <= '0;
      rstart_q    <= '0;
      rlines_q    <= '0;
      inv_pend_q  <= 1'b0;
      inv_act_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      line_q     <= line_d;
      height_q   <= height_d;
      run_open_q <= run_open_d;
      inv_pend_q <= inv_pend_d;
      inv_act_q  <= inv_act_d;
      if (hit && !run_open_q) run_start_q <= run_start_d;
      if (state_d == ST_EMIT && state_q == ST_SCAN) begin
        rstart_q <= rstart_d;
        rlines_q <= rlines_d;
      end
    end
  end

  assign band_idx    = line_q[LINE_W-1:2];
  assign scan_active = scan_step;
  assign rgn_valid   = (state_q == ST_EMIT);
  assign rgn_start   = rstart_q;
  assign rgn_lines   = rlines_q;
  assign clr_valid   = (state_q == ST_FIN) && span_any;
  assign clr_first   = span_lo;
  assign clr_last    = span_hi;
  assign done        = (state_q == ST_DONE);
endmodule

// File: rtl/dbt_tracker_chk.sv
module dbt_tracker_chk #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rgn_valid,
  input logic              rgn_ready,
  input logic [LINE_W-1:0] rgn_start,
  input logic [LINE_W-1:0] rgn_lines,
  input logic [LINE_W-3:0] band_idx,
  input logic              scan_active,
  input logic              clr_valid,
  input logic [LINE_W-3:0] clr_first,
  input logic [LINE_W-3:0] clr_last,
  input logic              done
);
  p_emit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid && !rgn_ready |=> rgn_valid && $stable(rgn_start) && $stable(rgn_lines));

  p_scan_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid && !rgn_ready |=> $stable(band_idx) && !scan_active);

  p_region_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid |-> rgn_lines != '0);

  p_clear_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_first <= clr_last);

  p_done_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !rgn_valid && !clr_valid);
endmodule

bind dbt_dirty_band_tracker dbt_tracker_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rgn_valid   (rgn_valid),
  .rgn_ready   (rgn_ready),
  .rgn_start   (rgn_start),
  .rgn_lines   (rgn_lines),
  .band_idx    (band_idx),
  .scan_active (scan_active),
  .clr_valid   (clr_valid),
  .clr_first   (clr_first),
  .clr_last    (clr_last),
  .done        (done)
);

// File: tb/dbt_dirty_band_tracker_test.sv
module dbt_dirty_band_tracker_test;
  localparam int LW = 7;
  localparam int NB = 1 << (LW - 2);

  logic clk, rst_n;
  logic frame_start, mixed_mode, invalidate_all, rgn_ready;
  logic [LW-1:0] frame_lines;
  logic [LW-3:0] band_idx, clr_first, clr_last;
  logic scan_active, rgn_valid, clr_valid, done;
  logic [LW-1:0] rgn_start, rgn_lines;
  logic [2:0] plane_dirty;

  bit p8 [NB];
  bit pd [NB];
  bit pc [NB];

  int n_cmp = 0;
  int n_bad = 0;
  bit inv_flag = 0;
  int lfsr = 32'h1d2b3c4;

  assign plane_dirty = {pc[band_idx], pd[band_idx], p8[band_idx]};

  dbt_dirty_band_tracker #(.LINE_W(LW), .NPLANES(3)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_lines(frame_lines),
    .mixed_mode(mixed_mode), .invalidate_all(invalidate_all), .band_idx(band_idx),
    .scan_active(scan_active), .plane_dirty(plane_dirty), .rgn_valid(rgn_valid),
    .rgn_ready(rgn_ready), .rgn_start(rgn_start), .rgn_lines(rgn_lines),
    .clr_valid(clr_valid), .clr_first(clr_first), .clr_last(clr_last), .done(done));

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_maps();
    for (int i = 0; i < NB; i++) begin p8[i] = 0; pd[i] = 0; pc[i] = 0; end
  endtask

  function automatic bit rnd_bit(input int pct);
    lfsr = lfsr * 1103515245 + 12345;
    return ((lfsr >>> 8) & 32'h7f) % 100 < pct;
  endfunction

  task automatic run_frame(input int h, input bit mx, input int stall_pct, input bit poke);
    int es[$], el[$];
    int run_s, lo, hi, cyc, kband, hs, hl;
    bit open, any, got_done, prev_hold, clr_prev, clr_seen;
    open = 0; any = 0; lo = 0; hi = 0; run_s = 0;
    for (int y = 0; y < h; y += 4) begin
      bit d;
      d = inv_flag | p8[y/4] | (mx & (pd[y/4] | pc[y/4]));
      if (d) begin
        if (!open) begin open = 1; run_s = y; end
        if (!any) lo = y/4;
        hi = y/4; any = 1;
      end else if (open) begin
        es.push_back(run_s); el.push_back(y - run_s); open = 0;
      end
    end
    if (open) begin es.push_back(run_s); el.push_back(h - run_s); end
    inv_flag = 0;

    frame_lines = LW'(h); mixed_mode = mx; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    cyc = 0; kband = 0; got_done = 0; prev_hold = 0; clr_prev = 0; clr_seen = 0;
    hs = 0; hl = 0;
    while (!got_done && cyc < 2000) begin
      frame_start = (poke && cyc == 3);
      rgn_ready = !rnd_bit(stall_pct);
      if (scan_active) begin
        chk(band_idx == kband, "R10 band order", band_idx, kband);
        kband++;
      end
      if (prev_hold) begin
        chk(rgn_valid && rgn_start == hs && rgn_lines == hl, "R8 hold", rgn_start, hs);
        chk(!scan_active, "R8 stall", scan_active, 0);
      end
      if (rgn_valid && rgn_ready) begin
        if (es.size() == 0) chk(0, "R3 unexpected region", rgn_start, -1);
        else begin
          int s, l;
          s = es.pop_front(); l = el.pop_front();
          chk(rgn_start == s, "R2 region start", rgn_start, s);
          chk(rgn_lines == l, "R3/R4 region lines", rgn_lines, l);
        end
      end
      prev_hold = rgn_valid && !rgn_ready;
      hs = rgn_start; hl = rgn_lines;
      if (clr_valid) begin
        chk(any, "R5 clear when dirty", 1, any);
        chk(clr_first == lo, "R5 clear first", clr_first, lo);
        chk(clr_last == hi, "R5 clear last", clr_last, hi);
        clr_seen = 1;
      end
      if (done) begin
        got_done = 1;
        chk(clr_seen == any, "R5 clear issued", clr_seen, any);
        chk(clr_prev == any, "R9 done after clear", clr_prev, any);
        chk(es.size() == 0, "R3 all regions out", es.size(), 0);
      end
      clr_prev = clr_valid;
      @(negedge clk);
      cyc++;
    end
    frame_start = 0;
    chk(got_done, "R9 done seen", got_done, 1);
    chk(!done, "R9 done single", done, 0);
    for (int i = 0; i < 6; i++) begin
      chk(!rgn_valid && !clr_valid && !done && !scan_active, "R9 idle after walk",
          {rgn_valid, clr_valid, done, scan_active}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; frame_start = 0; mixed_mode = 0; invalidate_all = 0; rgn_ready = 1;
    frame_lines = '0;
    clear_maps();
    repeat (3) @(negedge clk);
    chk(!rgn_valid && !clr_valid && !done && !scan_active, "R1 reset",
        {rgn_valid, clr_valid, done, scan_active}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rgn_valid && !clr_valid && !done && !scan_active, "R1 after release",
        {rgn_valid, clr_valid, done, scan_active}, 0);

    // R2 R3 R4: several runs, last band dirty
    p8[1] = 1; p8[2] = 1; p8[5] = 1; p8[15] = 1;
    run_frame(64, 0, 0, 0);
    // R6: other planes ignored in single mode
    pd[8] = 1; pc[9] = 1;
    run_frame(64, 0, 30, 0);
    // R6: counted in mixed mode
    run_frame(64, 1, 30, 0);
    // R4: partial last band
    clear_maps(); p8[6] = 1; p8[7] = 1;
    run_frame(30, 0, 50, 0);
    // R5: nothing dirty
    clear_maps();
    run_frame(40, 1, 0, 0);
    // R7: invalidate, then a clean walk
    invalidate_all = 1; @(negedge clk); invalidate_all = 0; inv_flag = 1;
    run_frame(48, 0, 40, 0);
    run_frame(48, 0, 0, 0);
    // R8 R9: alternating bands, heavy stall, restart ignored mid walk
    for (int i = 0; i < 8; i += 2) p8[i] = 1;
    run_frame(32, 0, 70, 1);
    // R2: first band and every band dirty
    clear_maps(); p8[0] = 1; p8[3] = 1;
    run_frame(16, 0, 0, 0);
    for (int i = 0; i < NB; i++) pc[i] = 1;
    run_frame(124, 1, 20, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule